// File: doc/BRIEF.md
# Sign-Extending Split Accumulator

This block is the result register of a multiply-accumulate unit. It keeps a 64-bit word of which only the low 56 bits carry meaning: every view of the register treats bit 55 as the sign and copies it into bits 63:56. Whatever the stored upper byte holds, readers never see it.

The block has two write paths. The datapath can load all 64 bits in one cycle. A debug port can read or write the register as two 32-bit halves, with a length field giving the access size in bytes. A half write is a read-modify-write of the sign-extended value: the addressed half takes the new data and the other half keeps its current sign-extended contents. Only 4-byte accesses are accepted. Any other length is refused and raises an error flag for one cycle.

Reads have no handshake. The sign-extended value and the selected half are always present on the outputs.

Top module: `acc_split_top`

## Requirements
- R1: After reset, the stored value is zero, `acc_value` and `hp_rdata` read 0, and `hp_err` is 0.
- R2: `acc_value` equals the stored low 56 bits, with bit 55 replicated into bits 63:56.
- R3: With `hp_sel`=0 (low half), `hp_rdata` is `acc_value[31:0]`.
- R4: With `hp_sel`=1 (high half), `hp_rdata` is `acc_value[63:32]`.
- R5: An accepted low-half write (`hp_en`=1, `hp_wr`=1, `hp_sel`=0, `hp_len`=4) stores `hp_wdata` in bits 31:0 at the next edge. Bits 63:32 take the pre-write `acc_value[63:32]`.
- R6: An accepted high-half write (`hp_sel`=1) stores `hp_wdata` in bits 63:32 and keeps the current bits 31:0.
- R7: `dp_we`=1 stores all 64 bits of `dp_wdata` unmodified at the next edge. The stored upper byte does not affect any read.
- R8: When `dp_we` and a half write occur in the same cycle, the datapath write wins and the half write is dropped.
- R9: A half-port access with `hp_en`=1 and `hp_len`≠4 leaves the stored value unchanged. It sets `hp_err` to 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_we | input | 1 | Datapath full-word write enable |
| dp_wdata | input | 64 | Datapath write data |
| hp_en | input | 1 | Half-port access strobe |
| hp_wr | input | 1 | Half-port access is a write |
| hp_sel | input | 1 | Half select: 0 low, 1 high |
| hp_len | input | 4 | Access length in bytes; only 4 is accepted |
| hp_wdata | input | 32 | Half-port write data |
| acc_value | output | 64 | Sign-extended register value |
| hp_rdata | output | 32 | Selected half of `acc_value` |
| hp_err | output | 1 | Length error, one cycle after a refused access |

## Verification
Writes land at the rising edge that samples them, so `acc_value` and `hp_rdata` show the new value one edge after the write. Reads are combinational: `hp_rdata` follows `hp_sel` with no delay. `hp_err` is registered and is due one edge after the refused access. The driver applies each operation just after a falling edge and sets the read select just after the rising edge. The monitor compares the queued expected item at the next falling edge, which sits exactly one edge after the operation.

// File: rtl/acc_split_pkg.sv
package acc_split_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/acc_sext.sv
module acc_sext #(
  parameter int W   = 64,
  parameter int SIG = 56
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] ext
);
  localparam logic [W-1:0] MASK = {{(W-SIG){1'b0}}, {SIG{1'b1}}};
  localparam logic [W-1:0] BIAS = W'(1) << (SIG - 1);

  logic [W-1:0] masked;

  always_comb begin
    masked = raw & MASK;
    ext    = (masked ^ BIAS) - BIAS;
  end

  // R2: the upper bits of the result all agree with the sign bit
  always_comb begin
    if (!$isunknown(raw)) begin
      assert_sign_fill_R2: assert ((&ext[W-1:SIG-1]) || !(|ext[W-1:SIG-1]));
    end
  end
endmodule

// File: rtl/acc_store.sv
module acc_store #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_we,
  input  logic [W-1:0]  dp_wdata,
  input  logic          hw_we,
  input  logic          hw_sel,
  input  logic [HW-1:0] hw_wdata,
  input  logic [W-1:0]  cur_ext,
  output logic [W-1:0]  raw
);
  import acc_split_pkg::*;
  localparam int UPW = W - HW;

  logic [W-1:0] merged;

  always_comb begin
    if (half_sel_e'(hw_sel) == HALF_HI)
      merged = {hw_wdata[UPW-1:0], cur_ext[HW-1:0]};
    else
      merged = {cur_ext[W-1:HW], hw_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw <= '0;
    else if (dp_we)   raw <= dp_wdata;
    else if (hw_we)   raw <= merged;
  end

  assert_dp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_we |=> raw == $past(dp_wdata));
  assert_dp_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && hw_we) |=> raw == $past(dp_wdata));
  assert_lo_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_we && hw_we && !hw_sel) |=> raw[W-1:HW] == $past(cur_ext[W-1:HW]));
  assert_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_we && hw_we && hw_sel) |=> raw[HW-1:0] == $past(raw[HW-1:0]));
endmodule

// File: rtl/acc_halfport.sv
module acc_halfport #(
  parameter int W    = 64,
  parameter int HW   = 32,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wr,
  input  logic            sel,
  input  logic [LENW-1:0] len,
  input  logic [W-1:0]    ext,
  output logic            wr_ok,
  output logic [HW-1:0]   rdata,
  output logic            err
);
  localparam logic [LENW-1:0] GOOD_LEN = LENW'(HW / 8);

  logic len_bad;

  always_comb begin
    len_bad = en && (len != GOOD_LEN);
    wr_ok   = en && wr && !len_bad;
    rdata   = sel ? ext[W-1:HW] : ext[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= len_bad;
  end

  assert_bad_len_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && len != GOOD_LEN) |=> err);
  assert_bad_len_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && len != GOOD_LEN) |-> !wr_ok);
endmodule

// File: rtl/acc_split_top.sv
module acc_split_top #(
  parameter int ACC_W  = 64,
  parameter int SIG_W  = 56,
  parameter int HALF_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_we,
  input  logic [ACC_W-1:0]  dp_wdata,
  input  logic              hp_en,
  input  logic              hp_wr,
  input  logic              hp_sel,
  input  logic [LEN_W-1:0]  hp_len,
  input  logic [HALF_W-1:0] hp_wdata,
  output logic [ACC_W-1:0]  acc_value,
  output logic [HALF_W-1:0] hp_rdata,
  output logic              hp_err
);
  logic [ACC_W-1:0] raw;
  logic             wr_ok;

  acc_sext #(.W(ACC_W), .SIG(SIG_W)) u_sext (
    .raw (raw),
    .ext (acc_value)
  );

  acc_halfport #(.W(ACC_W), .HW(HALF_W), .LENW(LEN_W)) u_port (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (hp_en),
    .wr    (hp_wr),
    .sel   (hp_sel),
    .len   (hp_len),
    .ext   (acc_value),
    .wr_ok (wr_ok),
    .rdata (hp_rdata),
    .err   (hp_err)
  );

  acc_store #(.W(ACC_W), .HW(HALF_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp_we    (dp_we),
    .dp_wdata (dp_wdata),
    .hw_we    (wr_ok),
    .hw_sel   (hp_sel),
    .hw_wdata (hp_wdata),
    .cur_ext  (acc_value),
    .raw      (raw)
  );

  assert_refused_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_we && hp_en && hp_len != LEN_W'(HALF_W / 8)) |=> $stable(acc_value));
endmodule

// File: tb/acc_split_top_test.sv
module acc_split_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp_we = 1'b0;
  logic [63:0] dp_wdata = '0;
  logic        hp_en = 1'b0, hp_wr = 1'b0, hp_sel = 1'b0;
  logic [3:0]  hp_len = 4'd4;
  logic [31:0] hp_wdata = '0;
  logic [63:0] acc_value;
  logic [31:0] hp_rdata;
  logic        hp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_split_top uut (
    .clk(clk), .rst_n(rst_n), .dp_we(dp_we), .dp_wdata(dp_wdata),
    .hp_en(hp_en), .hp_wr(hp_wr), .hp_sel(hp_sel), .hp_len(hp_len),
    .hp_wdata(hp_wdata), .acc_value(acc_value), .hp_rdata(hp_rdata),
    .hp_err(hp_err)
  );

  typedef struct {
    logic [63:0] acc;
    logic [31:0] rd;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [63:0] model = '0;
  bit          done = 1'b0;

  function automatic logic [63:0] sx(input logic [63:0] x);
    return {{8{x[55]}}, x[55:0]};
  endfunction

  task automatic push(input logic rsel, input logic err, input string tag);
    exp_t e;
    e.acc = sx(model);
    e.rd  = rsel ? e.acc[63:32] : e.acc[31:0];
    e.err = err;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic op(input logic dwe, input logic [63:0] dd, input logic hen,
                    input logic hwr, input logic hsel, input logic [3:0] hlen,
                    input logic [31:0] hd, input logic rsel, input string tag);
    logic [63:0] ext;
    logic        bad;
    @(negedge clk);
    #2;
    dp_we = dwe; dp_wdata = dd; hp_en = hen; hp_wr = hwr;
    hp_sel = hsel; hp_len = hlen; hp_wdata = hd;
    ext = sx(model);
    bad = hen && (hlen != 4'd4);
    if (dwe) model = dd;
    else if (hen && hwr && !bad)
      model = hsel ? {hd, ext[31:0]} : {ext[63:32], hd};
    @(posedge clk);
    #1;
    dp_we = 1'b0; hp_en = 1'b0; hp_wr = 1'b0; hp_sel = rsel; hp_len = 4'd4;
    push(rsel, bad, tag);
  endtask

  // monitor: compares one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (acc_value !== e.acc || hp_rdata !== e.rd || hp_err !== e.err) begin
          n_bad++;
          $display("FAIL %s: acc=%h rd=%h err=%b expected acc=%h rd=%h err=%b",
                   e.tag, acc_value, hp_rdata, hp_err, e.acc, e.rd, e.err);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: acc=%h expected completion", acc_value);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model = '0;
    push(1'b0, 1'b0, "R1 reset state");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    op(1, 64'h0000_0012_3456_789A, 0, 0, 0, 4, 0, 0, "R3 low read after load");
    op(0, 0, 0, 0, 0, 4, 0, 1, "R4 high read positive");
    op(1, 64'hAB80_0000_0000_0001, 0, 0, 0, 4, 0, 1, "R2 negative fill / R7");
    op(1, 64'h7F7F_FFFF_FFFF_FFFF, 0, 0, 0, 4, 0, 1, "R7 upper byte ignored");
    op(0, 0, 1, 1, 0, 4, 32'hDEAD_BEEF, 1, "R5 low write keeps high");
    op(0, 0, 1, 1, 1, 4, 32'h8000_0001, 0, "R6 high write keeps low");
    op(0, 0, 0, 0, 0, 4, 0, 1, "R2 sign from bit55 after high write");
    op(0, 0, 1, 1, 1, 4, 32'h0080_0000, 1, "R6 high write negative");
    op(1, 64'h1200_0000_1111_1111, 0, 0, 0, 4, 0, 1, "R7 garbage upper byte");
    op(0, 0, 1, 1, 0, 4, 32'h2222_2222, 1, "R5 merge uses extended high");
    op(1, 64'h0011_2233_4455_6677, 1, 1, 1, 4, 32'hFFFF_FFFF, 1, "R8 datapath wins");
    op(0, 0, 1, 1, 1, 4'd2, 32'hCAFE_F00D, 1, "R9 short write refused");
    op(0, 0, 0, 0, 0, 4, 0, 0, "R9 error clears");
    op(0, 0, 1, 0, 0, 4'd8, 0, 0, "R9 long read flagged");
    op(0, 0, 1, 1, 0, 4'd0, 32'h1234_5678, 0, "R9 zero length write refused");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule